// File: doc/BRIEF.md
# Repeating Pattern Sample Error Detector

This block checks a converter's parallel input bus against a fixed four-word test cycle. It is used while tuning board-level capture timing. The data clock or the data lines are skewed externally, and after each setting the sticky per-bit flags show which bit lanes were captured wrongly. One 16-bit word is taken on the rising edge of the data clock and one on the falling edge. The expected cycle is two clock periods long: the rising word of the first period is compared with I0, the falling word with Q0, the rising word of the second period with I1 and the falling word with Q1. The cycle then repeats.

A frame strobe arrives together with an I0 word, either once or on every I0. Each time it is seen it forces the compare pointer back to the I0/Q0 slot. Nothing is compared until the first strobe after enabling. The four expected words, the enable, the automatic-clear mode and its threshold are set through a byte-wide write port. Mismatches are flagged per bit, with the rising-edge and falling-edge lanes kept apart. The block only suits a repeating four-word characterization pattern and cannot follow live traffic.

Top module: `pattern_err_det`

## Requirements
- R1: After reset all error flags, `ever_fail_o`, `aligned_o` and `pass_o` are 0.
- R2: Write addresses 0 to 7 hold the expected words as bytes. Word k (0=I0, 1=Q0, 2=I1, 3=Q1) is {byte 2k+1, byte 2k}, with the low byte at the even address.
- R3: A rising-edge word is compared with I0 or I1, and a falling-edge word with Q0 or Q1 of the same slot. The slot alternates every clock. Each differing bit sets the matching bit of `err_rise_o` or `err_fall_o`.
- R4: `frame_i` is sampled with the rising-edge word. When it is high, that word pair is compared in the I0/Q0 slot, whatever the previous slot was.
- R5: While enabled, no comparison is made before the first frame strobe. `aligned_o` rises with that strobe.
- R6: An error bit stays set through later matching words until it is cleared.
- R7: Writing address 8 with bit 2 set clears both error vectors and `ever_fail_o`. This clear wins over a mismatch in the same cycle.
- R8: With auto-clear on (address 8 bit 1) and threshold T at address 9, with T nonzero, the error vectors clear after 2*T consecutive matching word pairs. T=0 disables auto-clear.
- R9: `ever_fail_o` sets on any mismatch and is not cleared by auto-clear.
- R10: `pass_o` is high only when enabled, aligned, and with both error vectors zero.
- R11: Address 8 bit 0 enables detection. While it is 0, no error bit sets and `aligned_o` drops.
- R12: A mismatch in the pair whose rising word is captured at clock edge k appears on the flags after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock; words are captured on both edges |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 16 | Input data bus |
| frame_i | input | 1 | Frame strobe, valid with the rising-edge word |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| err_rise_o | output | 16 | Sticky per-bit errors, rising-edge words |
| err_fall_o | output | 16 | Sticky per-bit errors, falling-edge words |
| ever_fail_o | output | 1 | Sticky any-mismatch flag |
| aligned_o | output | 1 | Frame strobe seen since enabling |
| pass_o | output | 1 | Enabled, aligned and error-free |

## Verification
The hardest state to reach is an auto-clear firing on exactly the right matching pair. That pair must sit after a mismatch, with the pattern pointer and the frame strobe kept in step across writes. The bench drives every clock with a pair that its model has chosen from the predicted slot. It counts 2*T clean pairs after a single flipped bit and samples the flags one pair before and one pair after the clear. A constrained random phase then mixes single-bit flips, frame strobes on I0 and occasional clear writes against the same model.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int NUM_WORDS = 4;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_AUTO = 1;
  localparam int CTRL_CLR  = 2;
endpackage

// File: rtl/pd_ddr_capture.sv
module pd_ddr_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         frame_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic         frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_o  <= '0;
      frame_o <= 1'b0;
    end else begin
      rise_o  <= data_i;
      frame_o <= frame_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_o <= '0;
    else         fall_o <= data_i;
  end
endmodule

// File: rtl/pd_regfile.sv
module pd_regfile import pd_pkg::*; #(
  parameter int W  = 16,
  parameter int AW = 4,
  parameter int TW = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [7:0]                    wr_data_i,
  output logic [NUM_WORDS-1:0][W-1:0]   words_o,
  output logic                          en_o,
  output logic                          auto_o,
  output logic                          clr_o,
  output logic [TW-1:0]                 thr_o
);
  localparam int BPW    = W / 8;
  localparam int NBYTES = NUM_WORDS * BPW;
  localparam int A_CTRL = NBYTES;
  localparam int A_THR  = NBYTES + 1;

  logic [7:0] bytes_q [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
      en_o   <= 1'b0;
      auto_o <= 1'b0;
      thr_o  <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NBYTES; i++)
        if (wr_addr_i == AW'(i)) bytes_q[i] <= wr_data_i;
      if (wr_addr_i == AW'(A_CTRL)) begin
        en_o   <= wr_data_i[CTRL_EN];
        auto_o <= wr_data_i[CTRL_AUTO];
      end
      if (wr_addr_i == AW'(A_THR)) thr_o <= TW'(wr_data_i);
    end
  end

  // clear is a write pulse, not stored
  assign clr_o = wr_en_i && (wr_addr_i == AW'(A_CTRL)) && wr_data_i[CTRL_CLR];

  for (genvar g = 0; g < NBYTES; g++) begin : g_word
    assign words_o[g / BPW][(g % BPW)*8 +: 8] = bytes_q[g];
  end
endmodule

// File: rtl/pd_compare.sv
module pd_compare import pd_pkg::*; #(
  parameter int W  = 16,
  parameter int TW = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [W-1:0]                rise_i,
  input  logic [W-1:0]                fall_i,
  input  logic                        frame_i,
  input  logic [NUM_WORDS-1:0][W-1:0] words_i,
  input  logic                        en_i,
  input  logic                        auto_i,
  input  logic                        clr_i,
  input  logic [TW-1:0]               thr_i,
  output logic [W-1:0]                err_rise_o,
  output logic [W-1:0]                err_fall_o,
  output logic                        ever_fail_o,
  output logic                        aligned_o
);
  logic          slot_q, slot_cur, active, any_miss, auto_hit;
  logic [W-1:0]  exp_r, exp_f, miss_r, miss_f;
  logic [TW:0]   cnt_q, cnt_n;

  // frame forces the I0/Q0 slot
  assign slot_cur = frame_i ? 1'b0 : slot_q;
  assign active   = en_i && (aligned_o || frame_i);
  assign exp_r    = slot_cur ? words_i[2] : words_i[0];
  assign exp_f    = slot_cur ? words_i[3] : words_i[1];
  assign miss_r   = active ? (rise_i ^ exp_r) : '0;
  assign miss_f   = active ? (fall_i ^ exp_f) : '0;
  assign any_miss = |{miss_r, miss_f};
  assign cnt_n    = cnt_q + 1'b1;
  assign auto_hit = active && !any_miss && auto_i && (thr_i != '0)
                    && (cnt_n == {thr_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= 1'b0;
      aligned_o   <= 1'b0;
      cnt_q       <= '0;
      err_rise_o  <= '0;
      err_fall_o  <= '0;
      ever_fail_o <= 1'b0;
    end else begin
      aligned_o <= en_i ? (aligned_o | frame_i) : 1'b0;

      if (!en_i)       slot_q <= 1'b0;
      else if (active) slot_q <= ~slot_cur;

      if (clr_i || !en_i) cnt_q <= '0;
      else if (active)    cnt_q <= (any_miss || auto_hit) ? '0 : cnt_n;

      if (clr_i || auto_hit) begin
        err_rise_o <= '0;
        err_fall_o <= '0;
      end else begin
        err_rise_o <= err_rise_o | miss_r;
        err_fall_o <= err_fall_o | miss_f;
      end

      ever_fail_o <= clr_i ? 1'b0 : (ever_fail_o | any_miss);
    end
  end
endmodule

// File: rtl/pattern_err_det.sv
module pattern_err_det import pd_pkg::*; #(
  parameter int W  = 16,
  parameter int AW = 4,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic          frame_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic [W-1:0]  err_rise_o,
  output logic [W-1:0]  err_fall_o,
  output logic          ever_fail_o,
  output logic          aligned_o,
  output logic          pass_o
);
  logic [W-1:0]                rise_w, fall_w;
  logic                        frame_w, en_w, auto_w, clr_w;
  logic [TW-1:0]               thr_w;
  logic [NUM_WORDS-1:0][W-1:0] words_w;

  pd_ddr_capture #(.W(W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .frame_i (frame_i),
    .rise_o  (rise_w),
    .fall_o  (fall_w),
    .frame_o (frame_w)
  );

  pd_regfile #(.W(W), .AW(AW), .TW(TW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .words_o   (words_w),
    .en_o      (en_w),
    .auto_o    (auto_w),
    .clr_o     (clr_w),
    .thr_o     (thr_w)
  );

  pd_compare #(.W(W), .TW(TW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .frame_i     (frame_w),
    .words_i     (words_w),
    .en_i        (en_w),
    .auto_i      (auto_w),
    .clr_i       (clr_w),
    .thr_i       (thr_w),
    .err_rise_o  (err_rise_o),
    .err_fall_o  (err_fall_o),
    .ever_fail_o (ever_fail_o),
    .aligned_o   (aligned_o)
  );

  assign pass_o = en_w && aligned_o && (err_rise_o == '0) && (err_fall_o == '0);
endmodule

// File: rtl/pattern_err_det_chk.sv
module pattern_err_det_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         auto_i,
  input logic         clr_i,
  input logic [W-1:0] err_rise_i,
  input logic [W-1:0] err_fall_i,
  input logic         ever_fail_i
);
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !auto_i) |=> (((err_rise_i & $past(err_rise_i)) == $past(err_rise_i))
                          && ((err_fall_i & $past(err_fall_i)) == $past(err_fall_i))));

  // R9
  ever_covers_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_rise_i != '0) || (err_fall_i != '0)) |-> ever_fail_i);

  // R9
  ever_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ever_fail_i && !clr_i) |=> ever_fail_i);

  // R11
  no_new_err_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (((err_rise_i & ~$past(err_rise_i)) == '0)
            && ((err_fall_i & ~$past(err_fall_i)) == '0)));
endmodule

bind pattern_err_det pattern_err_det_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_w),
  .auto_i      (auto_w),
  .clr_i       (clr_w),
  .err_rise_i  (err_rise_o),
  .err_fall_i  (err_fall_o),
  .ever_fail_i (ever_fail_o)
);

// File: tb/pattern_err_det_bench.sv
module pattern_err_det_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        frame_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [15:0] err_rise_o, err_fall_o;
  logic        ever_fail_o, aligned_o, pass_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pattern_err_det u_pattern_err_det (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .frame_i(frame_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .err_rise_o(err_rise_o), .err_fall_o(err_fall_o),
    .ever_fail_o(ever_fail_o), .aligned_o(aligned_o), .pass_o(pass_o)
  );

  // reference model state
  logic [15:0] m_w [4];
  bit          m_en, m_auto, m_al, m_slot, m_ev;
  logic [7:0]  m_thr;
  logic [15:0] m_er, m_ef;
  logic [8:0]  m_cnt;
  logic [15:0] p_r, p_f;
  bit          p_frm;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic commit(bit clr);
    bit sc, act, hit, miss;
    logic [15:0] mr, mf;
    logic [8:0] cn;
    sc   = p_frm ? 1'b0 : m_slot;
    act  = m_en && (m_al || p_frm);
    mr   = act ? (p_r ^ (sc ? m_w[2] : m_w[0])) : 16'h0;
    mf   = act ? (p_f ^ (sc ? m_w[3] : m_w[1])) : 16'h0;
    miss = (mr != 0) || (mf != 0);
    cn   = m_cnt + 9'd1;
    hit  = act && !miss && m_auto && (m_thr != 0) && (cn == {m_thr, 1'b0});
    if (clr || !m_en) m_cnt = '0;
    else if (act)     m_cnt = (miss || hit) ? 9'd0 : cn;
    if (clr || hit) begin m_er = '0; m_ef = '0; end
    else begin m_er |= mr; m_ef |= mf; end
    m_ev = clr ? 1'b0 : (m_ev | miss);
    if (!m_en)    m_slot = 1'b0;
    else if (act) m_slot = !sc;
    m_al = m_en ? (m_al | p_frm) : 1'b0;
  endtask

  function automatic bit nxt_slot();
    bit sc = p_frm ? 1'b0 : m_slot;
    if (!m_en) return 1'b0;
    if (m_al || p_frm) return !sc;
    return m_slot;
  endfunction

  task automatic step(logic [15:0] r, logic [15:0] f, bit frm,
                      bit we, logic [3:0] wa, logic [7:0] wd);
    @(negedge clk); #5;
    data_i = r; frame_i = frm; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    @(posedge clk); #5;
    commit(we && wa == 4'd8 && wd[2]);
    if (we) begin
      if (wa < 4'd8) begin
        if (wa[0]) m_w[wa[2:1]][15:8] = wd;
        else       m_w[wa[2:1]][7:0]  = wd;
      end else if (wa == 4'd8) begin
        m_en = wd[0]; m_auto = wd[1];
      end else if (wa == 4'd9) m_thr = wd;
    end
    p_r = r; p_frm = frm; p_f = f;
    data_i = f; frame_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic bad(logic [15:0] fr, logic [15:0] ff, bit frm);
    bit s = frm ? 1'b0 : nxt_slot();
    step(m_w[{s, 1'b0}] ^ fr, m_w[{s, 1'b1}] ^ ff, frm, 1'b0, 4'd0, 8'd0);
  endtask

  task automatic good(bit frm);
    bad(16'h0, 16'h0, frm);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bit s = nxt_slot();
    step(m_w[{s, 1'b0}], m_w[{s, 1'b1}], 1'b0, 1'b1, a, d);
  endtask

  task automatic check_state(string req);
    bit mp = m_en && m_al && (m_er == 0) && (m_ef == 0);
    chk(req, 64'({err_rise_o, err_fall_o, ever_fail_o, aligned_o, pass_o}),
             64'({m_er, m_ef, m_ev, m_al, mp}));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] pat [4];
    void'($urandom(32'd2024));
    pat[0] = 16'hA5C3; pat[1] = 16'h0F1E; pat[2] = 16'h7788; pat[3] = 16'h1234;
    for (int i = 0; i < 4; i++) m_w[i] = '0;
    m_en = 0; m_auto = 0; m_al = 0; m_slot = 0; m_ev = 0; m_thr = 0;
    m_er = 0; m_ef = 0; m_cnt = 0; p_r = 0; p_f = 0; p_frm = 0;
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    // R1
    chk("R1 reset flags", 64'({err_rise_o, err_fall_o, ever_fail_o, aligned_o, pass_o}), 64'h0);

    for (int i = 0; i < 8; i++) wr(4'(i), i[0] ? pat[i/2][15:8] : pat[i/2][7:0]);
    wr(4'd8, 8'h01);
    repeat (3) bad(16'hFFFF, 16'hFFFF, 1'b0);
    // R5: no comparison before the first frame
    chk("R5 no frame no errors", 64'({err_rise_o, err_fall_o, ever_fail_o, aligned_o}), 64'h0);

    good(1'b1);
    repeat (5) good(1'b0);
    // R2: byte-loaded words match the driven pattern
    chk("R2 R10 aligned clean pass", 64'({err_rise_o, err_fall_o, ever_fail_o, aligned_o, pass_o}), 64'h3);

    if (nxt_slot() == 1'b0) good(1'b0);
    bad(16'h0, 16'h0020, 1'b0);
    chk("R12 flags not yet set", 64'(err_fall_o), 64'h0);
    good(1'b0);
    chk("R3 Q1 bit5 fall error", 64'({err_rise_o, err_fall_o}), 64'h0000_0020);
    repeat (3) good(1'b0);
    chk("R6 sticky through clean words", 64'(err_fall_o), 64'h0020);
    chk("R10 pass low with error", 64'({ever_fail_o, pass_o}), 64'h2);

    if (nxt_slot() == 1'b1) good(1'b0);
    bad(16'h8001, 16'h0, 1'b0);
    good(1'b0);
    chk("R3 I0 rise error", 64'(err_rise_o), 64'h8001);

    wr(4'd8, 8'h05);
    chk("R7 manual clear", 64'({err_rise_o, err_fall_o, ever_fail_o}), 64'h0);
    bad(16'h0001, 16'h0, 1'b0);
    wr(4'd8, 8'h05);
    chk("R7 clear wins same cycle", 64'({err_rise_o, err_fall_o, ever_fail_o}), 64'h0);

    if (nxt_slot() == 1'b0) good(1'b0);
    good(1'b1);
    repeat (4) good(1'b0);
    chk("R4 realign mid cycle", 64'({err_rise_o, err_fall_o, ever_fail_o}), 64'h0);
    step(m_w[2], m_w[3], 1'b1, 1'b0, 4'd0, 8'd0);
    good(1'b0);
    chk("R4 frame forces I0 slot", 64'({err_rise_o, err_fall_o}), 64'hD24B_1D2A);

    wr(4'd8, 8'h00);
    repeat (3) bad(16'hFFFF, 16'hFFFF, 1'b1);
    chk("R11 disabled no new errors", 64'({err_rise_o, err_fall_o}), 64'hD24B_1D2A);
    chk("R11 disabled drops aligned", 64'({aligned_o, pass_o}), 64'h0);

    wr(4'd8, 8'h01);
    repeat (3) bad(16'hFFFF, 16'hFFFF, 1'b0);
    chk("R5 reenable waits for frame", 64'({err_rise_o, err_fall_o, aligned_o}), 64'h1_A496_3A54);

    wr(4'd8, 8'h05);
    good(1'b1);
    wr(4'd9, 8'd3);
    wr(4'd8, 8'h03);
    bad(16'h0, 16'h0001, 1'b0);
    repeat (6) good(1'b0);
    chk("R8 before threshold", 64'(err_fall_o), 64'h0001);
    good(1'b0);
    chk("R8 auto clear", 64'({err_rise_o, err_fall_o}), 64'h0);
    chk("R9 ever kept after auto clear", 64'(ever_fail_o), 64'h1);
    check_state("R8 R9 model");

    for (int n = 0; n < 400; n++) begin
      bit s, frm;
      logic [15:0] fr, ff;
      s   = nxt_slot();
      frm = (s == 1'b0) && ($urandom % 4 == 0);
      fr  = ($urandom % 6 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      ff  = ($urandom % 6 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      if ($urandom % 40 == 0)
        step(m_w[{s, 1'b0}] ^ fr, m_w[{s, 1'b1}] ^ ff, frm, 1'b1, 4'd8,
             8'h05 | 8'(($urandom % 2) << 1));
      else
        step(m_w[{s, 1'b0}] ^ fr, m_w[{s, 1'b1}] ^ ff, frm, 1'b0, 4'd0, 8'd0);
      check_state("R3 R6 R8 R9 R10 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule